// File: doc/BRIEF.md
# Tagged Call and Address Stack

This block is the single hardware stack of a small program sequencer. Two kinds of entry live on it: return references written by subroutine calls, and four-component integer address vectors saved by an explicit push-address command. One depth counter covers both, and every entry carries a one-bit tag that records which kind it is. When an entry is popped, its tag is checked against the command that pops it. A mismatch, an overflow or an underflow stops the program abnormally.

The sequencer sends one command per valid cycle. The four commands are call, return, push-address and pop-address. With each command it also sends the fall-through program counter and the call target. For a return it also sends four pass/fail bits from the condition-code test, which is evaluated outside this block. One clock edge later the block reports the next program counter and, for a pop-address, the restored address vector. It also holds two sticky status flags, one for normal end and one for abnormal end. A program-start pulse empties the stack and clears both flags.

Top module: `tagged_call_stack`

## Requirements
- R1: After reset or a `start_i` pulse, `depth_o` is 0, `done_o` and `abort_o` are low, and `pc_vld_o` and `addr_vld_o` are low.
- R2: A call (`cmd_i`=0) pushes `seq_pc_i` with the return tag and, one cycle later, shows `nxt_pc_o`=`tgt_pc_i` with `pc_vld_o` high. A call issued when `depth_o` equals DEPTH raises `abort_o` and leaves the depth unchanged.
- R3: A push-address (`cmd_i`=2) stores `addr_i` exactly as given, with the address tag, and reports `nxt_pc_o`=`seq_pc_i`. A push-address issued when `depth_o` equals DEPTH raises `abort_o` and leaves the depth unchanged.
- R4: A pop-address (`cmd_i`=3) issued on an empty stack raises `abort_o`.
- R5: A pop-address whose top entry carries the return tag raises `abort_o` and leaves the depth unchanged.
- R6: A pop-address whose top entry carries the address tag outputs all 40 bits on `addr_o` with `addr_vld_o` high. It also lowers the depth by one and reports `nxt_pc_o`=`seq_pc_i`.
- R7: A return (`cmd_i`=1) with `cond_i`=0 leaves the stack unchanged and reports `nxt_pc_o`=`seq_pc_i`.
- R8: A return with at least one `cond_i` bit set, issued on an empty stack, sets `done_o` and leaves `abort_o` low.
- R9: A taken return whose top entry carries the address tag raises `abort_o`.
- R10: A taken return whose top entry carries the return tag reports that stored value on `nxt_pc_o` and lowers the depth by one.
- R11: `done_o` and `abort_o` stay set until `start_i`. While either flag is set, commands change neither the depth nor the outputs, and `pc_vld_o` stays low.
- R12: Both entry kinds share one last-in-first-out order and one depth count, so interleaved calls, pushes, returns and pops unwind in reverse order of entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Program start: empties the stack and clears the flags |
| cmd_vld_i | input | 1 | A command is present this cycle |
| cmd_i | input | 2 | 0 call, 1 return, 2 push-address, 3 pop-address |
| cond_i | input | 4 | Per-component condition test results for a return |
| seq_pc_i | input | 16 | Fall-through program counter |
| tgt_pc_i | input | 16 | Call target |
| addr_i | input | 40 | Address vector to push, four 10-bit components |
| nxt_pc_o | output | 16 | Next program counter |
| pc_vld_o | output | 1 | `nxt_pc_o` is valid for the last command |
| addr_o | output | 40 | Address vector restored by the last pop-address |
| addr_vld_o | output | 1 | `addr_o` was updated by the last command |
| depth_o | output | 4 | Current stack depth |
| done_o | output | 1 | Sticky normal-end flag |
| abort_o | output | 1 | Sticky abnormal-end flag |

## Verification
The embedded assertions check four things on every cycle: the depth never goes past DEPTH, the termination flags stay set, the stack is frozen after termination, and a start pulse clears the state. They also check that an untaken return leaves the depth alone. Only the bench scenarios can show the rest. That covers tag checking on pops, the exact values that return in last-in-first-out order across mixed entry kinds, and the difference between a normal end on an empty return and an abnormal end on overflow or underflow.

// File: rtl/tstk_pkg.sv
// Shared command encoding and default geometry for the tagged call stack.
package tstk_pkg;
    localparam int PC_W_D  = 16;
    localparam int AC_W_D  = 10;
    localparam int N_AC_D  = 4;
    localparam int DEPTH_D = 8;

    typedef enum logic [1:0] {
        CMD_CALL  = 2'd0,
        CMD_RET   = 2'd1,
        CMD_PUSHA = 2'd2,
        CMD_POPA  = 2'd3
    } cmd_e;
endpackage

// File: rtl/tstk_store.sv
// Entry storage for the tagged stack.
// Assumes: at most one write per cycle, and reads only touch entries below the current depth.
module tstk_store #(
    parameter int DEPTH = 8,
    parameter int EW    = 41,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] wptr,
    input  logic [EW-1:0] wdata,
    input  logic [PW-1:0] rptr,
    output logic [EW-1:0] rdata
);
    logic [EW-1:0] ent [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        // Each entry loads only when it is the write target.
        always_ff @(posedge clk) begin
            if (we && (wptr == PW'(g))) ent[g] <= wdata;
        end
    end

    // Asynchronous read of the top-of-stack entry.
    always_comb rdata = ent[rptr];
endmodule

// File: rtl/tstk_ctrl.sv
// Control for the tagged stack: depth counter, tag checks, overflow and underflow
// handling, return condition, the sticky end flags and the registered outputs.
// Assumes: cond_i is already swizzled and tested outside; tag 1 means address entry.
module tstk_ctrl
    import tstk_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PC_W  = 16,
    parameter int AW    = 40,
    localparam int DW   = (PC_W > AW) ? PC_W : AW,
    localparam int EW   = DW + 1,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int DPW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            cmd_vld_i,
    input  logic [1:0]      cmd_i,
    input  logic [3:0]      cond_i,
    input  logic [PC_W-1:0] seq_pc_i,
    input  logic [PC_W-1:0] tgt_pc_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [EW-1:0]   top_i,
    output logic            we_o,
    output logic [PW-1:0]   wptr_o,
    output logic [EW-1:0]   wdata_o,
    output logic [PW-1:0]   rptr_o,
    output logic [PC_W-1:0] nxt_pc_o,
    output logic            pc_vld_o,
    output logic [AW-1:0]   addr_o,
    output logic            addr_vld_o,
    output logic [DPW-1:0]  depth_o,
    output logic            done_o,
    output logic            abort_o
);
    logic [DPW-1:0] depth_q;
    logic           done_q, abort_q;
    logic           empty, full, running, top_addr, taken;
    logic           push, pop, set_abort, set_done, pcv_n, addrv_n;
    logic [PC_W-1:0] pc_n;
    logic [DW-1:0]  pc_ext;
    cmd_e           cmd;

    assign cmd      = cmd_e'(cmd_i);
    assign empty    = (depth_q == '0);
    assign full     = (depth_q == DPW'(DEPTH));
    assign running  = !done_q && !abort_q;
    assign top_addr = top_i[EW-1];
    assign taken    = |cond_i;
    assign wptr_o   = depth_q[PW-1:0];
    assign rptr_o   = PW'(depth_q - 1'b1);

    // Zero-extend the fall-through counter into an entry payload.
    always_comb begin
        pc_ext = '0;
        pc_ext[PC_W-1:0] = seq_pc_i;
    end

    // Decode one command into stack moves, status changes and the next outputs.
    always_comb begin
        push = 1'b0; pop = 1'b0; set_abort = 1'b0; set_done = 1'b0;
        pcv_n = 1'b0; addrv_n = 1'b0; pc_n = seq_pc_i;
        wdata_o = {1'b0, pc_ext};
        if (cmd_vld_i && running && !start_i) begin
            unique case (cmd)
                CMD_CALL: begin
                    if (full) set_abort = 1'b1;
                    else begin push = 1'b1; pc_n = tgt_pc_i; pcv_n = 1'b1; end
                end
                CMD_RET: begin
                    if (!taken) pcv_n = 1'b1;
                    else if (empty) set_done = 1'b1;
                    else if (top_addr) set_abort = 1'b1;
                    else begin pop = 1'b1; pc_n = top_i[PC_W-1:0]; pcv_n = 1'b1; end
                end
                CMD_PUSHA: begin
                    wdata_o = {1'b1, DW'(addr_i)};
                    if (full) set_abort = 1'b1;
                    else begin push = 1'b1; pcv_n = 1'b1; end
                end
                CMD_POPA: begin
                    if (empty || !top_addr) set_abort = 1'b1;
                    else begin pop = 1'b1; addrv_n = 1'b1; pcv_n = 1'b1; end
                end
                default: ;
            endcase
        end
        we_o = push;
    end

    // Depth, sticky flags and registered outputs, cleared by reset or start.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            depth_q    <= '0;
            done_q     <= 1'b0;
            abort_q    <= 1'b0;
            pc_vld_o   <= 1'b0;
            addr_vld_o <= 1'b0;
            nxt_pc_o   <= '0;
            addr_o     <= '0;
        end else begin
            if (push) depth_q <= depth_q + 1'b1;
            else if (pop) depth_q <= depth_q - 1'b1;
            if (set_done)  done_q  <= 1'b1;
            if (set_abort) abort_q <= 1'b1;
            pc_vld_o   <= pcv_n;
            addr_vld_o <= addrv_n;
            if (pcv_n)   nxt_pc_o <= pc_n;
            if (addrv_n) addr_o   <= top_i[AW-1:0];
        end
    end

    assign depth_o = depth_q;
    assign done_o  = done_q;
    assign abort_o = abort_q;

    // R3 and R2: the depth never exceeds the configured maximum.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        depth_o <= DPW'(DEPTH));
    // R11: the abnormal flag holds until a start pulse.
    a_r11_abort_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_o && !start_i) |=> abort_o);
    // R11: the normal-end flag holds until a start pulse.
    a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);
    // R11: after termination the depth is frozen and no PC is reported.
    a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_o || abort_o) && !start_i) |=> ($stable(depth_o) && !pc_vld_o));
    // R1: a start pulse empties the stack and clears the flags.
    a_r1_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (depth_o == '0 && !done_o && !abort_o && !pc_vld_o));
    // R7: an untaken return leaves the depth unchanged.
    a_r7_untaken: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld_i && cmd_i == 2'd1 && cond_i == 4'd0 && !start_i) |=> $stable(depth_o));
endmodule

// File: rtl/tagged_call_stack.sv
// Top of the tagged call and address stack: wires control to entry storage.
// Assumes: one command per cycle; results show one clock edge after the command.
module tagged_call_stack
    import tstk_pkg::*;
#(
    parameter int DEPTH = DEPTH_D,
    parameter int PC_W  = PC_W_D,
    parameter int AC_W  = AC_W_D,
    parameter int N_AC  = N_AC_D,
    localparam int AW   = AC_W * N_AC,
    localparam int DW   = (PC_W > AW) ? PC_W : AW,
    localparam int EW   = DW + 1,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int DPW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            cmd_vld_i,
    input  logic [1:0]      cmd_i,
    input  logic [3:0]      cond_i,
    input  logic [PC_W-1:0] seq_pc_i,
    input  logic [PC_W-1:0] tgt_pc_i,
    input  logic [AW-1:0]   addr_i,
    output logic [PC_W-1:0] nxt_pc_o,
    output logic            pc_vld_o,
    output logic [AW-1:0]   addr_o,
    output logic            addr_vld_o,
    output logic [DPW-1:0]  depth_o,
    output logic            done_o,
    output logic            abort_o
);
    logic          we;
    logic [PW-1:0] wptr, rptr;
    logic [EW-1:0] wdata, top;

    tstk_ctrl #(.DEPTH(DEPTH), .PC_W(PC_W), .AW(AW)) ctrl_i (
        .clk, .rst_n, .start_i, .cmd_vld_i, .cmd_i, .cond_i,
        .seq_pc_i, .tgt_pc_i, .addr_i,
        .top_i(top), .we_o(we), .wptr_o(wptr), .wdata_o(wdata), .rptr_o(rptr),
        .nxt_pc_o, .pc_vld_o, .addr_o, .addr_vld_o, .depth_o, .done_o, .abort_o
    );

    tstk_store #(.DEPTH(DEPTH), .EW(EW)) store_i (
        .clk, .we, .wptr, .wdata, .rptr, .rdata(top)
    );
endmodule

// File: tb/tagged_call_stack_tb_top.sv
// Self-checking bench: a vector table for the main flow, then directed corner cases.
module tagged_call_stack_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, start_i = 1'b0, cmd_vld_i = 1'b0;
    logic [1:0]  cmd_i = '0;
    logic [3:0]  cond_i = '0;
    logic [15:0] seq_pc_i = '0, tgt_pc_i = '0, nxt_pc_o;
    logic [39:0] addr_i = '0, addr_o;
    logic        pc_vld_o, addr_vld_o, done_o, abort_o;
    logic [3:0]  depth_o;
    int          errs = 0, checks = 0;

    always #2.5 clk = ~clk;

    tagged_call_stack dut_i (.*);

    localparam logic [39:0] A1 = {10'h3FF, 10'h001, 10'h200, 10'h155};
    localparam logic [39:0] A2 = {10'h012, 10'h3F0, 10'h000, 10'h2AA};
    // Fields: cmd, cond, seq, tgt, addr, exp_pc, exp_depth, exp_pcv, exp_addrv, exp_addr
    localparam int VW = 2+4+16+16+40+16+4+1+1+40;
    localparam int NV = 7;
    localparam logic [VW-1:0] TBL [NV] = '{
        {2'd0, 4'h0, 16'h0011, 16'h0100, 40'h0, 16'h0100, 4'd1, 1'b1, 1'b0, 40'h0},
        {2'd2, 4'h0, 16'h0102, 16'h0000, A1,    16'h0102, 4'd2, 1'b1, 1'b0, 40'h0},
        {2'd0, 4'h0, 16'h0103, 16'h0200, 40'h0, 16'h0200, 4'd3, 1'b1, 1'b0, 40'h0},
        {2'd1, 4'h0, 16'h0201, 16'h0000, 40'h0, 16'h0201, 4'd3, 1'b1, 1'b0, 40'h0},
        {2'd1, 4'h4, 16'h0202, 16'h0000, 40'h0, 16'h0103, 4'd2, 1'b1, 1'b0, 40'h0},
        {2'd3, 4'h0, 16'h0104, 16'h0000, 40'h0, 16'h0104, 4'd1, 1'b1, 1'b1, A1},
        {2'd1, 4'h8, 16'h0105, 16'h0000, 40'h0, 16'h0011, 4'd0, 1'b1, 1'b0, 40'h0}
    };
    localparam string TREQ [NV] = '{"R2", "R3", "R12", "R7", "R10", "R6", "R12"};

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] c, input logic [3:0] cd,
                         input logic [15:0] sq, input logic [15:0] tg, input logic [39:0] a);
        @(negedge clk);
        cmd_vld_i = 1'b1; cmd_i = c; cond_i = cd; seq_pc_i = sq; tgt_pc_i = tg; addr_i = a;
        @(negedge clk);
        cmd_vld_i = 1'b0;
    endtask

    task automatic restart();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errs++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(depth_o == 0, "R1", "depth", 64'(depth_o), 0);
        chk(!done_o && !abort_o, "R1", "flags", {done_o, abort_o}, 0);
        chk(!pc_vld_o && !addr_vld_o, "R1", "valids", {pc_vld_o, addr_vld_o}, 0);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = TBL[i];
            issue(v[VW-1 -: 2], v[VW-3 -: 4], v[VW-7 -: 16], v[VW-23 -: 16], v[VW-39 -: 40]);
            chk(pc_vld_o == v[41], TREQ[i], "pc_vld", 64'(pc_vld_o), 64'(v[41]));
            chk(nxt_pc_o == v[61:46], TREQ[i], "nxt_pc", 64'(nxt_pc_o), 64'(v[61:46]));
            chk(depth_o == v[45:42], TREQ[i], "depth", 64'(depth_o), 64'(v[45:42]));
            chk(addr_vld_o == v[40], TREQ[i], "addr_vld", 64'(addr_vld_o), 64'(v[40]));
            if (v[40]) chk(addr_o == v[39:0], TREQ[i], "addr", 64'(addr_o), 64'(v[39:0]));
            chk(!abort_o && !done_o, TREQ[i], "no end", {done_o, abort_o}, 0);
        end

        // R4: pop-address on empty
        issue(2'd3, 4'h0, 16'h0300, 16'h0, 40'h0);
        chk(abort_o, "R4", "abort", 64'(abort_o), 1);
        chk(!done_o, "R4", "done", 64'(done_o), 0);
        // R11: commands ignored after termination
        issue(2'd0, 4'h0, 16'h0301, 16'h0400, 40'h0);
        chk(depth_o == 0 && !pc_vld_o, "R11", "ignored call", {depth_o, pc_vld_o}, 0);
        chk(abort_o, "R11", "abort held", 64'(abort_o), 1);
        restart();
        chk(!abort_o && depth_o == 0, "R1", "start clears", {abort_o, depth_o}, 0);

        // R9: return onto an address entry
        issue(2'd2, 4'h0, 16'h0010, 16'h0, A2);
        issue(2'd1, 4'h1, 16'h0011, 16'h0, 40'h0);
        chk(abort_o, "R9", "abort", 64'(abort_o), 1);
        chk(!pc_vld_o && depth_o == 1, "R9", "pcv/depth", {pc_vld_o, depth_o}, 64'h1);
        restart();

        // R5: pop-address onto a return entry
        issue(2'd0, 4'h0, 16'h0020, 16'h0500, 40'h0);
        issue(2'd3, 4'h0, 16'h0501, 16'h0, 40'h0);
        chk(abort_o, "R5", "abort", 64'(abort_o), 1);
        chk(depth_o == 1, "R5", "depth", 64'(depth_o), 1);
        restart();

        // R8: taken return on empty stack ends normally
        issue(2'd1, 4'h2, 16'h0030, 16'h0, 40'h0);
        chk(done_o && !abort_o, "R8", "done/abort", {done_o, abort_o}, 64'h2);
        issue(2'd2, 4'h0, 16'h0031, 16'h0, A1);
        chk(depth_o == 0 && done_o, "R11", "ignored push after done", {depth_o, done_o}, 64'h1);
        restart();

        // R3: push-address into a full stack (mixed fill, R12 shared depth)
        for (int k = 0; k < 8; k++)
            issue((k % 2) ? 2'd2 : 2'd0, 4'h0, 16'(k), 16'h0600, A2);
        chk(depth_o == 8 && !abort_o, "R12", "shared depth", {depth_o, abort_o}, 64'h10);
        issue(2'd2, 4'h0, 16'h0040, 16'h0, A1);
        chk(abort_o && depth_o == 8, "R3", "overflow", {abort_o, depth_o}, 64'h18);
        restart();

        // R2: call into a full stack
        for (int k = 0; k < 8; k++) issue(2'd0, 4'h0, 16'(k), 16'h0700, 40'h0);
        issue(2'd0, 4'h0, 16'h0050, 16'h0800, 40'h0);
        chk(abort_o && depth_o == 8, "R2", "overflow", {abort_o, depth_o}, 64'h18);
        chk(nxt_pc_o == 16'h0700, "R2", "pc held", 64'(nxt_pc_o), 64'h0700);

        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule